// File: doc/BRIEF.md
# Receive Overhead Serial Output Port

This block takes the transport overhead bytes of a received SONET/SDH frame and sends them out on a one-bit serial port. The port has three outputs: a gapped port clock, a data line and a frame marker. The bytes come in through a byte-wide write port. Each byte is addressed by its STS-1 index and its overhead slot. The host writes one frame's worth of overhead between two frame-start strobes. On the next strobe those bytes become the frame that is sent, and the other bank opens for capture.

The port clock is derived from the system clock. A fractional pacer spreads the bits evenly so that, with one strobe every `FRAME_CLKS` system cycles (125 µs), the whole frame's overhead goes out exactly once per period. That is 648 bits in STS-3 mode and 2592 bits in STS-12 mode. The port clock sits high and drops low for a single system cycle per bit. Data and marker change only at that falling edge, so an external receiver captures on the following rising edge. The marker is high only while the most significant bit of the first A1 byte is on the data line.

Top module: `ovh_rx_serial_port`

## Requirements
- R1: After reset `ovh_ser_clk` is 1 and `ovh_ser_data` and `ovh_ser_mark` are 0. No bit is sent until the first `frame_start`.
- R2: Each frame sends 27 × 8 bits per STS-1: 648 bits when the mode sampled at the strobe is 0 (STS-3) and 2592 bits when it is 1 (STS-12). With strobes `FRAME_CLKS` cycles apart, all of them are sent before the next strobe.
- R3: Bytes go out slot-major, STS-interleaved and MSB first. All STS-1s send slot 0, in STS index order, before any STS-1 sends slot 1, and so on up to slot 26. A slot number is the row-major position in the 9×3 overhead area: slot 0 = A1, slot 1 = A2, slot 26 = E2.
- R4: `ovh_ser_mark` is 1 exactly for the first bit of a frame, which is bit 7 of slot 0 of STS index 0. Every other bit carries 0. Exactly one marked bit is sent per strobe.
- R5: For each bit, `ovh_ser_clk` is low for exactly one system cycle. `ovh_ser_data` and `ovh_ser_mark` change only in the cycles when the port clock is low. The port clock is never low in two consecutive cycles.
- R6: The bytes sent after a strobe are the bytes written between that strobe and the one before it. Writes made while a frame is being sent do not change that frame.
- R7: `sts12_mode` is sampled only at `frame_start`. Changing it in the middle of a frame has no effect on that frame.
- R8: In STS-3 mode only STS indices 0 to 2 are sent. Bytes stored for higher indices do not appear.
- R9: A write with `ovh_wr_sts` ≥ `MAX_STS` or `ovh_wr_slot` ≥ 27 is ignored and alters no stored byte.
- R10: Once the last bit of a frame has gone out, the port clock stays high until the next `frame_start`, even if that strobe is late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame strobe; swaps banks and starts a frame |
| sts12_mode | input | 1 | 1 = STS-12, 0 = STS-3; sampled at `frame_start` |
| ovh_wr_en | input | 1 | Overhead byte write enable |
| ovh_wr_sts | input | STS_W (4) | STS-1 index of the written byte |
| ovh_wr_slot | input | SLOT_W (5) | Overhead slot (0 to 26) of the written byte |
| ovh_wr_data | input | 8 | Overhead byte value |
| ovh_ser_clk | output | 1 | Gapped port clock; low one cycle per bit |
| ovh_ser_data | output | 1 | Serial overhead data |
| ovh_ser_mark | output | 1 | Frame marker on the first bit |

## Verification
The bench targets the following corner cases:
- **Late strobe.** A design whose pacer runs on after the last bit would emit stray bits in the gap.
- **Mode change mid-frame.** A design that reads the mode pin live would change the interleave partway through a frame, and the per-frame bit count would go wrong.
- **Writes during a send.** A design without working bank separation would send some bytes from the following frame.
- **Out-of-range writes.** A design that lets these through would alias them onto valid bytes, because STS index 12 to 15 of slot s maps onto slot s+1.
- **Serial timing.** Stale data from the one-cycle memory read would appear as bits shifted by one byte, and a marker placed on the wrong bit would break the per-frame bit count.

// File: rtl/ovh_ser_pkg.sv
package ovh_ser_pkg;
  // overhead byte positions per STS-1 (9 rows x 3 columns)
  localparam int OVH_SLOTS = 27;
  localparam int BYTE_W    = 8;

  function automatic int frame_bits(input int n_sts);
    return n_sts * OVH_SLOTS * BYTE_W;
  endfunction
endpackage

// File: rtl/ovh_frame_buf.sv
// Two-bank overhead byte store: one write port, one registered read port.
module ovh_frame_buf
  import ovh_ser_pkg::*;
#(
  parameter int MAX_STS = 12,
  parameter int STS_W   = 4,
  parameter int SLOT_W  = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [STS_W-1:0]  wr_sts,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [7:0]        wr_data,
  input  logic              rd_bank,
  input  logic [STS_W-1:0]  rd_sts,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [7:0]        rd_data
);
  localparam int IDX_W = $clog2(OVH_SLOTS * MAX_STS);
  localparam int DEPTH = 2 ** (IDX_W + 1);

  logic [7:0] mem [DEPTH];
  logic       wr_ok;

  // slot-major layout: all STS-1s of one slot sit side by side
  function automatic logic [IDX_W-1:0] byte_idx(input logic [SLOT_W-1:0] slot,
                                                input logic [STS_W-1:0]  sts);
    return IDX_W'(int'(slot) * MAX_STS + int'(sts));
  endfunction

  // R9: out-of-range coordinates never reach the memory
  assign wr_ok = wr_en && (int'(wr_sts) < MAX_STS) && (int'(wr_slot) < OVH_SLOTS);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[{wr_bank, byte_idx(wr_slot, wr_sts)}] <= wr_data;
    rd_data <= mem[{rd_bank, byte_idx(rd_slot, rd_sts)}];
  end
endmodule

// File: rtl/ovh_bit_pacer.sv
// Fractional bit pacer: inc ticks spread evenly over FRAME_CLKS cycles.
module ovh_bit_pacer #(
  parameter int FRAME_CLKS = 6250,
  parameter int INC_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [INC_W-1:0] inc,
  output logic             tick
);
  localparam int ACC_W = $clog2(FRAME_CLKS + 2 ** INC_W) + 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum  = acc + ACC_W'(inc);
  assign tick = run && !restart && (sum >= ACC_W'(FRAME_CLKS));

  // starting at inc puts the last tick one cycle before the next strobe
  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (restart) acc <= ACC_W'(inc);
    else if (tick)    acc <= sum - ACC_W'(FRAME_CLKS);
    else if (run)     acc <= sum;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ovh_frame_seq.sv
// Bit / STS / slot position counters for the frame being sent.
module ovh_frame_seq
  import ovh_ser_pkg::*;
#(
  parameter int STS_W  = 4,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic [STS_W-1:0]  last_sts,
  output logic [STS_W-1:0]  cur_sts,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [2:0]        bit_idx,
  output logic              active,
  output logic              first
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cur_sts  <= '0;
      cur_slot <= '0;
      bit_idx  <= '0;
    end else if (restart) begin
      active   <= 1'b1;
      cur_sts  <= '0;
      cur_slot <= '0;
      bit_idx  <= '0;
    end else if (tick && active) begin
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) begin
        if (cur_sts == last_sts) begin
          cur_sts <= '0;
          if (cur_slot == SLOT_W'(OVH_SLOTS - 1)) begin
            cur_slot <= '0;
            active   <= 1'b0;
          end else begin
            cur_slot <= cur_slot + 1'b1;
          end
        end else begin
          cur_sts <= cur_sts + 1'b1;
        end
      end
    end
  end

  assign first = active && (cur_sts == '0) && (cur_slot == '0) && (bit_idx == 3'd0);

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> ((int'(cur_slot) < OVH_SLOTS) && (cur_sts <= last_sts)));

  // R10
  start_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(restart));
endmodule

// File: rtl/ovh_rx_serial_port.sv
module ovh_rx_serial_port
  import ovh_ser_pkg::*;
#(
  parameter int MAX_STS    = 12,
  parameter int LOW_STS    = 3,
  parameter int FRAME_CLKS = 6250,
  localparam int STS_W     = $clog2(MAX_STS),
  localparam int SLOT_W    = $clog2(OVH_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              sts12_mode,
  input  logic              ovh_wr_en,
  input  logic [STS_W-1:0]  ovh_wr_sts,
  input  logic [SLOT_W-1:0] ovh_wr_slot,
  input  logic [7:0]        ovh_wr_data,
  output logic              ovh_ser_clk,
  output logic              ovh_ser_data,
  output logic              ovh_ser_mark
);
  localparam int BITS_HI = frame_bits(MAX_STS);
  localparam int BITS_LO = frame_bits(LOW_STS);
  localparam int INC_W   = $clog2(BITS_HI + 1);

  logic              cap_bank;
  logic              mode_q;
  logic [INC_W-1:0]  inc;
  logic [STS_W-1:0]  last_sts;
  logic              tick;
  logic [STS_W-1:0]  cur_sts;
  logic [SLOT_W-1:0] cur_slot;
  logic [2:0]        bit_idx;
  logic              active;
  logic              first;
  logic [7:0]        rd_data;
  logic              tick_q;
  logic [2:0]        bitsel_q;
  logic              first_q;

  // R6, R7: bank swap and mode capture happen only at the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_bank <= 1'b0;
      mode_q   <= 1'b0;
    end else if (frame_start) begin
      cap_bank <= ~cap_bank;
      mode_q   <= sts12_mode;
    end
  end

  assign inc      = (frame_start ? sts12_mode : mode_q) ? INC_W'(BITS_HI) : INC_W'(BITS_LO);
  assign last_sts = mode_q ? STS_W'(MAX_STS - 1) : STS_W'(LOW_STS - 1);

  ovh_frame_buf #(.MAX_STS(MAX_STS), .STS_W(STS_W), .SLOT_W(SLOT_W)) buf_i (
    .clk     (clk),
    .wr_en   (ovh_wr_en),
    .wr_bank (cap_bank),
    .wr_sts  (ovh_wr_sts),
    .wr_slot (ovh_wr_slot),
    .wr_data (ovh_wr_data),
    .rd_bank (~cap_bank),
    .rd_sts  (cur_sts),
    .rd_slot (cur_slot),
    .rd_data (rd_data)
  );

  ovh_bit_pacer #(.FRAME_CLKS(FRAME_CLKS), .INC_W(INC_W)) pacer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (frame_start),
    .run     (active),
    .inc     (inc),
    .tick    (tick)
  );

  ovh_frame_seq #(.STS_W(STS_W), .SLOT_W(SLOT_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .restart  (frame_start),
    .tick     (tick),
    .last_sts (last_sts),
    .cur_sts  (cur_sts),
    .cur_slot (cur_slot),
    .bit_idx  (bit_idx),
    .active   (active),
    .first    (first)
  );

  // one-cycle delay lets the registered memory read settle before the bit leaves
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q       <= 1'b0;
      bitsel_q     <= '0;
      first_q      <= 1'b0;
      ovh_ser_clk  <= 1'b1;
      ovh_ser_data <= 1'b0;
      ovh_ser_mark <= 1'b0;
    end else begin
      tick_q   <= tick;
      bitsel_q <= bit_idx;
      first_q  <= first;
      if (tick_q) begin
        ovh_ser_clk  <= 1'b0;
        ovh_ser_data <= rd_data[3'd7 - bitsel_q];
        ovh_ser_mark <= first_q;
      end else begin
        ovh_ser_clk  <= 1'b1;
      end
    end
  end

  // R5
  edge_align_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ovh_ser_data) || !$stable(ovh_ser_mark)) |-> !ovh_ser_clk);

  // R5
  clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ovh_ser_clk |=> ovh_ser_clk);
endmodule

// File: tb/ovh_rx_serial_port_tb.sv
module ovh_rx_serial_port_tb_top;
  localparam int MAX_STS = 12;
  localparam int LOW_STS = 3;
  localparam int FC      = 6250;
  localparam int SLOTS   = 27;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_sts = '0;
  logic [4:0] wr_slot = '0;
  logic [7:0] wr_data = '0;
  logic       sclk, sdata, smark;

  always #10 clk = ~clk;

  ovh_rx_serial_port #(.MAX_STS(MAX_STS), .LOW_STS(LOW_STS), .FRAME_CLKS(FC)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .sts12_mode(mode),
    .ovh_wr_en(wr_en), .ovh_wr_sts(wr_sts), .ovh_wr_slot(wr_slot), .ovh_wr_data(wr_data),
    .ovh_ser_clk(sclk), .ovh_ser_data(sdata), .ovh_ser_mark(smark)
  );

  int checks = 0, errors = 0;
  logic [7:0] nxt  [MAX_STS][SLOTS];
  logic [7:0] snap [MAX_STS][SLOTS];
  logic [7:0] cur  [MAX_STS][SLOTS];
  logic  snap_mode = 1'b0, cur_mode = 1'b0;
  string snap_tag = "", cur_tag = "";
  int bitpos = 0, frames_seen = 0, strobes = 0, lows = 0, bad_bits = 0, early_bits = 0;
  bit prev_low = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nbits(input logic m);
    return (m ? MAX_STS : LOW_STS) * SLOTS * 8;
  endfunction

  // expected bit: slot-major, STS-interleaved, MSB first (R3, R8)
  function automatic logic exp_bit(input int pos);
    int n, byte_i, slot, sts;
    n      = cur_mode ? MAX_STS : LOW_STS;
    byte_i = pos / 8;
    slot   = byte_i / n;
    sts    = byte_i % n;
    if (slot >= SLOTS) return 1'b0;
    return cur[sts][slot][7 - (pos % 8)];
  endfunction

  // serial monitor: one bit per low port-clock cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (!sclk) begin
        lows++;
        if (prev_low) check(1'b0, "R5", "port clock low two cycles", 1, 0);
        if (smark) begin
          if (frames_seen > 0) begin
            check(bitpos == nbits(cur_mode), "R2", "bits between markers", bitpos, nbits(cur_mode));
            check(bad_bits == 0, cur_tag, "mismatched bits in frame", bad_bits, 0);
          end
          cur = snap; cur_mode = snap_mode; cur_tag = snap_tag;
          bitpos = 0; bad_bits = 0; frames_seen++;
        end
        if (frames_seen > 0) begin
          if (sdata !== exp_bit(bitpos)) bad_bits++;
          bitpos++;
        end else begin
          early_bits++;
        end
      end
      prev_low = !sclk;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_frame(input bit with_bad, output int used);
    used = 0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int t = 0; t < MAX_STS; t++) begin
        nxt[t][s] = 8'($urandom);
        wr_en = 1'b1; wr_sts = 4'(t); wr_slot = 5'(s); wr_data = nxt[t][s];
        @(negedge clk); used++;
      end
    end
    if (with_bad) begin
      // R9: STS index 12..15 would alias onto the next slot; slot 27..31 is outside the area
      for (int k = 0; k < 24; k++) begin
        wr_sts  = (k % 2 == 0) ? 4'(12 + $urandom % 4) : 4'($urandom % 12);
        wr_slot = (k % 2 == 0) ? 5'($urandom % 27) : 5'(27 + $urandom % 5);
        wr_data = 8'($urandom);
        @(negedge clk); used++;
      end
    end
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input logic m, input bit flip, input bit bad, input int gap, input string tag);
    int used, w, l0;
    mode = m; frame_start = 1'b1;
    snap = nxt; snap_mode = m; snap_tag = tag; strobes++;
    @(negedge clk); frame_start = 1'b0; used = 1;
    write_frame(bad, w); used += w;
    if (flip) begin
      wait_n(FC / 2 - used); used = FC / 2;
      mode = ~m;   // R7: must not affect the frame in flight
    end
    wait_n(FC - used);
    if (gap > 0) begin
      wait_n(5); l0 = lows; wait_n(gap - 5);
      check(lows == l0, "R10", "port clock pulses during late-strobe gap", lows - l0, 0);
    end
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired, stream stalled", 0, 1);
    finish_sim();
  end

  initial begin
    int w;
    void'($urandom(32'd7351));
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    check(sclk == 1'b1, "R1", "port clock after reset", int'(sclk), 1);
    check(sdata == 1'b0, "R1", "data after reset", int'(sdata), 0);
    check(smark == 1'b0, "R1", "marker after reset", int'(smark), 0);
    write_frame(1'b0, w);
    check(lows == 0, "R1", "bits before first strobe", lows, 0);

    run_frame(1'b0, 1'b0, 1'b0, 0,   "R3 R6 R8");
    run_frame(1'b1, 1'b0, 1'b0, 0,   "R3 R4 R6");
    run_frame(1'b1, 1'b1, 1'b0, 0,   "R7");
    run_frame(1'b0, 1'b1, 1'b0, 0,   "R7 R8");
    run_frame(1'b1, 1'b0, 1'b1, 0,   "R9");
    run_frame(1'b0, 1'b0, 1'b1, 300, "R9 R10");
    run_frame(1'b1, 1'b0, 1'b0, 700, "R10 R6");
    for (int i = 0; i < 5; i++) begin
      run_frame(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 0, "R3 R6 random");
    end
    // closing strobe ends the last frame's count
    mode = 1'b0; frame_start = 1'b1; strobes++;
    @(negedge clk); frame_start = 1'b0;
    wait_n(40);
    check(frames_seen == strobes, "R4", "marked frames vs strobes", frames_seen, strobes);
    check(early_bits == 0, "R4", "bits without a leading marker", early_bits, 0);
    finish_sim();
  end
endmodule